// File: doc/BRIEF.md
# Serially Programmed Clock Fan-out Enable Controller

This block sits between a two-wire serial bus (I2C, write direction only) and a fan-out of ten copies of one reference clock. A host addresses the block, sends two filler bytes that the block acknowledges and throws away, and then sends three data bytes. Those bytes carry a sparse set of per-output enable bits. An output whose bit is set carries the reference clock. An output whose bit is cleared is held at a static low. A separate global output-enable pin overrides everything and puts all ten outputs into high impedance. The block cannot be read back and never stretches the clock.

The bus lines are sampled with a fast system clock through a synchronizer. START and STOP conditions are recovered from the sampled lines, and a small receive engine shifts bytes in, decides on acknowledges and issues register writes. The acknowledge is a single open-drain pull-down request. The pad outside the block turns it into a low on SDA.

Top module: `clkbuf_i2c_ctl`

## Requirements
- R1: An address byte of 0xD2 (7-bit device address 1101001, followed by R/W = 0 for a write) is acknowledged. `sda_oe_o` = 1 (pull SDA low) during the ninth SCL clock of that byte.
- R2: An address byte with any other 7-bit address, or with R/W = 1 (for example 0xD3), is not acknowledged. Every later byte, including bytes that look like a valid frame, is then ignored and not acknowledged until the next START. The enables do not change.
- R3: Every byte is received most significant bit first. The first data bit after SCL rises is bit 7.
- R4: Once the address is accepted, every following byte is acknowledged: the command byte, the count byte, data bytes 0 to 2, and any later bytes. The acknowledge changes only while SCL is low.
- R5: The first two bytes after the address are discarded. Their values never reach any enable.
- R6: In data byte 0 (the third byte after the address), bits 3..0 set the enables of outputs 3..0. Bits 7..4 have no effect.
- R7: In data byte 1, bits 7..4 set the enables of outputs 7..4. Bits 3..0 have no effect.
- R8: In data byte 2, bit 7 sets the enable of output 9 and bit 6 sets the enable of output 8. Bits 5..0 have no effect.
- R9: With the global enable high, an output whose enable is 1 equals `ref_clk_i`. An output whose enable is 0 is driven low.
- R10: Reset sets all ten enables to 1.
- R11: When `out_en_i` = 0, all bits of `clk_oe_o` are 0 (all outputs high impedance), whatever the enables hold. When `out_en_i` = 1, all bits of `clk_oe_o` are 1.
- R12: Bytes after data byte 2 are acknowledged and discarded. A START or STOP inside a frame aborts the frame. Data bytes already completed keep their values, and a partly received byte is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial bus clock line |
| sda_i | input | 1 | Serial bus data line as seen at the pad |
| sda_oe_o | output | 1 | 1 = pull SDA low (acknowledge) |
| ref_clk_i | input | 1 | Reference clock to distribute |
| out_en_i | input | 1 | Global output enable, 0 = all outputs high impedance |
| clk_o | output | 10 | Gated clock outputs |
| clk_oe_o | output | 10 | Per-output tristate enables, 1 = drive |

## Verification
A wrong byte counter or a wrong address decision shows at the ports within one byte time. The acknowledge appears or goes missing in the ninth clock of the byte concerned. A wrong bit-to-output mapping shows as a wrong `clk_o` pattern as soon as the frame's last data byte has been acknowledged and the reference clock is held high. Stale or wrong enables after an aborted or refused frame show at the next static sample of `clk_o`. The acknowledge is therefore checked byte by byte, and the output pattern is checked after every frame.

// File: rtl/clkbuf_pkg.sv
package clkbuf_pkg;
    localparam int NUM_OUT = 10;

    // byte positions inside a frame, counted from the address byte (0)
    localparam logic [2:0] POS_DATA0 = 3'd3;
    localparam logic [2:0] POS_DATA2 = 3'd5;
    localparam logic [2:0] POS_SAT   = 3'd6;

    typedef enum logic [1:0] {
        ST_IDLE,   // waiting for START (also the "ignore" state)
        ST_BITS,   // shifting in a byte
        ST_ACKW,   // byte done, wait for SCL low to drive ACK
        ST_ACK     // ACK driven, wait for SCL low to release
    } rx_state_e;

    typedef struct packed {
        rx_state_e  st;
        logic [2:0] bitcnt;
        logic [7:0] shreg;
        logic [2:0] bytepos;
        logic       ack;
        logic       wr;
        logic [1:0] widx;
        logic [7:0] wdata;
    } rx_regs_t;
endpackage

// File: rtl/clkbuf_bus_sync.sv
module clkbuf_bus_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int W = STAGES + 1;

    typedef struct packed {
        logic [W-1:0] scl;
        logic [W-1:0] sda;
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    always_comb begin
        pipe_d     = pipe_q;
        pipe_d.scl = {pipe_q.scl[W-2:0], scl_i};
        pipe_d.sda = {pipe_q.sda[W-2:0], sda_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '1;
        else        pipe_q <= pipe_d;
    end

    logic scl_p, sda_p;
    assign scl_s = pipe_q.scl[W-2];
    assign sda_s = pipe_q.sda[W-2];
    assign scl_p = pipe_q.scl[W-1];
    assign sda_p = pipe_q.sda[W-1];

    assign scl_rise  =  scl_s & ~scl_p;
    assign scl_fall  = ~scl_s &  scl_p;
    assign start_det =  scl_s &  scl_p &  sda_p & ~sda_s;
    assign stop_det  =  scl_s &  scl_p & ~sda_p &  sda_s;
endmodule

// File: rtl/clkbuf_rx_engine.sv
module clkbuf_rx_engine
    import clkbuf_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'b1101001
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sda_s,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       start_det,
    input  logic       stop_det,
    output logic       ack_o,
    output logic       wr_o,
    output logic [1:0] widx_o,
    output logic [7:0] wdata_o
);
    localparam logic [7:0] WR_BYTE = {DEV_ADDR, 1'b0};

    rx_regs_t   r_d, r_q;
    logic [7:0] byte_nx;
    logic [2:0] rel_pos;

    always_comb begin
        r_d     = r_q;
        r_d.wr  = 1'b0;
        byte_nx = {r_q.shreg[6:0], sda_s};
        rel_pos = r_q.bytepos - POS_DATA0;
        if (start_det) begin
            r_d.st      = ST_BITS;
            r_d.bitcnt  = 3'd0;
            r_d.bytepos = 3'd0;
            r_d.ack     = 1'b0;
        end else if (stop_det) begin
            r_d.st  = ST_IDLE;
            r_d.ack = 1'b0;
        end else begin
            case (r_q.st)
                ST_BITS: if (scl_rise) begin
                    r_d.shreg  = byte_nx;
                    r_d.bitcnt = r_q.bitcnt + 3'd1;
                    if (r_q.bitcnt == 3'd7) begin
                        if (r_q.bytepos == 3'd0 && byte_nx != WR_BYTE)
                            r_d.st = ST_IDLE;
                        else
                            r_d.st = ST_ACKW;
                        if (r_q.bytepos >= POS_DATA0 && r_q.bytepos <= POS_DATA2) begin
                            r_d.wr    = 1'b1;
                            r_d.widx  = rel_pos[1:0];
                            r_d.wdata = byte_nx;
                        end
                    end
                end
                ST_ACKW: if (scl_fall) begin
                    r_d.ack = 1'b1;
                    r_d.st  = ST_ACK;
                end
                ST_ACK: if (scl_fall) begin
                    r_d.ack    = 1'b0;
                    r_d.st     = ST_BITS;
                    r_d.bitcnt = 3'd0;
                    if (r_q.bytepos != POS_SAT) r_d.bytepos = r_q.bytepos + 3'd1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: ST_IDLE, default: '0};
        else        r_q <= r_d;
    end

    assign ack_o   = r_q.ack;
    assign wr_o    = r_q.wr;
    assign widx_o  = r_q.widx;
    assign wdata_o = r_q.wdata;
endmodule

// File: rtl/clkbuf_en_regs.sv
module clkbuf_en_regs
    import clkbuf_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_i,
    input  logic [1:0]         widx_i,
    input  logic [7:0]         wdata_i,
    output logic [NUM_OUT-1:0] en_o
);
    logic [NUM_OUT-1:0] en_d, en_q;

    always_comb begin
        en_d = en_q;
        if (wr_i) begin
            case (widx_i)
                2'd0:    en_d[3:0] = wdata_i[3:0];
                2'd1:    en_d[7:4] = wdata_i[7:4];
                2'd2:    en_d[9:8] = {wdata_i[7], wdata_i[6]};
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en_q <= '1;
        else        en_q <= en_d;
    end

    assign en_o = en_q;
endmodule

// File: rtl/clkbuf_out_gate.sv
module clkbuf_out_gate #(
    parameter int N = 10
) (
    input  logic         ref_clk_i,
    input  logic         out_en_i,
    input  logic [N-1:0] en_i,
    output logic [N-1:0] clk_o,
    output logic [N-1:0] oe_o
);
    for (genvar i = 0; i < N; i++) begin : g_lane
        assign clk_o[i] = ref_clk_i & en_i[i];
        assign oe_o[i]  = out_en_i;
    end
endmodule

// File: rtl/clkbuf_i2c_ctl.sv
module clkbuf_i2c_ctl
    import clkbuf_pkg::*;
#(
    parameter int         SYNC_STAGES = 2,
    parameter logic [6:0] DEV_ADDR    = 7'b1101001
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    output logic               sda_oe_o,
    input  logic               ref_clk_i,
    input  logic               out_en_i,
    output logic [NUM_OUT-1:0] clk_o,
    output logic [NUM_OUT-1:0] clk_oe_o
);
    logic               scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic               wr_stb;
    logic [1:0]         wr_idx;
    logic [7:0]         wr_data;
    logic [NUM_OUT-1:0] en_q;

    clkbuf_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    clkbuf_rx_engine #(.DEV_ADDR(DEV_ADDR)) u_rx (
        .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
        .ack_o(sda_oe_o), .wr_o(wr_stb), .widx_o(wr_idx), .wdata_o(wr_data)
    );

    clkbuf_en_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_i(wr_stb), .widx_i(wr_idx),
        .wdata_i(wr_data), .en_o(en_q)
    );

    clkbuf_out_gate #(.N(NUM_OUT)) u_gate (
        .ref_clk_i(ref_clk_i), .out_en_i(out_en_i), .en_i(en_q),
        .clk_o(clk_o), .oe_o(clk_oe_o)
    );
endmodule

// File: rtl/clkbuf_i2c_chk.sv
module clkbuf_i2c_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_s,
    input logic       start_det,
    input logic       stop_det,
    input logic       sda_ack,
    input logic       wr_stb,
    input logic [9:0] en_q,
    input logic [9:0] clk_oe_o
);
    // R4
    ack_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_ack) |-> !scl_s);

    // R12
    start_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> !sda_ack);

    // R12
    stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_ack);

    // R5
    en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb |=> $stable(en_q));

    // R11
    oe_uniform_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_oe_o == 10'h000) || (clk_oe_o == 10'h3FF));
endmodule

bind clkbuf_i2c_ctl clkbuf_i2c_chk u_chk (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .start_det(start_det),
    .stop_det(stop_det), .sda_ack(sda_oe_o), .wr_stb(wr_stb),
    .en_q(en_q), .clk_oe_o(clk_oe_o)
);

// File: tb/clkbuf_i2c_ctl_test.sv
`timescale 1ns/1ps
module clkbuf_i2c_ctl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       ref_clk = 1'b0;
    logic       oe_pin = 1'b1;
    logic       sda_oe;
    logic [9:0] clk_o, clk_oe;
    wire        sda_line = sda_m & ~sda_oe;

    int total = 0;
    int bad = 0;
    logic [9:0] exp_en = 10'h3FF;

    always #2.5 clk = ~clk;

    clkbuf_i2c_ctl uut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_oe_o(sda_oe), .ref_clk_i(ref_clk), .out_en_i(oe_pin),
        .clk_o(clk_o), .clk_oe_o(clk_oe)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hp();
        repeat (10) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; hp(); scl_m = 1'b1; hp();
        sda_m = 1'b0; hp(); scl_m = 1'b0; repeat (2) @(negedge clk);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; hp(); scl_m = 1'b1; hp(); sda_m = 1'b1; hp();
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda_m = b[i]; hp(); scl_m = 1'b1; hp();
            scl_m = 1'b0; repeat (2) @(negedge clk);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        send_bits(b, 8);
        sda_m = 1'b1; hp(); scl_m = 1'b1;
        repeat (5) @(negedge clk);
        ack = sda_oe;
        repeat (5) @(negedge clk);
        scl_m = 1'b0; repeat (2) @(negedge clk);
    endtask

    // expected model of the enables from the data bytes
    task automatic model_write(input int idx, input logic [7:0] d);
        case (idx)
            0: exp_en[3:0] = d[3:0];
            1: exp_en[7:4] = d[7:4];
            2: exp_en[9:8] = {d[7], d[6]};
            default: ;
        endcase
    endtask

    task automatic check_outputs(input string req);
        oe_pin = 1'b1; ref_clk = 1'b1; @(negedge clk);
        check(clk_o == exp_en, req, 32'(clk_o), 32'(exp_en));
        check(clk_oe == 10'h3FF, {req, "/R11"}, 32'(clk_oe), 32'h3FF);
        ref_clk = 1'b0; @(negedge clk);
        check(clk_o == 10'h000, {req, "/R9 low"}, 32'(clk_o), 32'h0);
    endtask

    task automatic frame(input logic [7:0] a, input logic [7:0] c, input logic [7:0] n,
                         input logic [7:0] d0, input logic [7:0] d1, input logic [7:0] d2,
                         input string req);
        bit ack;
        int acks = 0;
        bit good = (a == 8'hD2);
        bus_start();
        send_byte(a, ack);  acks += int'(ack);
        send_byte(c, ack);  acks += int'(ack);
        send_byte(n, ack);  acks += int'(ack);
        send_byte(d0, ack); acks += int'(ack);
        send_byte(d1, ack); acks += int'(ack);
        send_byte(d2, ack); acks += int'(ack);
        bus_stop();
        if (good) begin
            model_write(0, d0); model_write(1, d1); model_write(2, d2);
        end
        check(acks == (good ? 6 : 0), {req, " acks R1/R2/R4"}, 32'(acks), good ? 32'd6 : 32'd0);
        check_outputs(req);
    endtask

    initial begin
        int cyc = 0;
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 190000) begin
                bad++; total++;
                $display("FAIL watchdog actual=%0d expected=done", cyc);
                $display("  test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        bit ack;
        int acks;
        logic [7:0] a, c, n, d0, d1, d2;
        void'($urandom(32'd4711));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R10: reset state, all enabled
        check_outputs("R10 reset");
        check(sda_oe == 1'b0, "R10 no ack at reset", 32'(sda_oe), 32'h0);

        // R6/R7/R8/R5: distinct patterns, filler bytes nonzero
        frame(8'hD2, 8'hFF, 8'h00, 8'hF0, 8'h0F, 8'h3F, "R6/R7/R8 clear all");
        frame(8'hD2, 8'h5A, 8'hA5, 8'h0F, 8'hF0, 8'hC0, "R5/R8 set all");
        // R3: msb first, 0x0A vs bit-reversed 0x50
        frame(8'hD2, 8'h00, 8'h00, 8'h0A, 8'hA0, 8'h80, "R3 msb order");

        // R11: global enable low tristates everything
        oe_pin = 1'b0; ref_clk = 1'b1; @(negedge clk);
        check(clk_oe == 10'h000, "R11 oe low", 32'(clk_oe), 32'h0);
        oe_pin = 1'b1; ref_clk = 1'b0;

        // R2: read address and wrong address, then fake frame without new START
        frame(8'hD3, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, "R2 rw=1");
        bus_start();
        acks = 0;
        send_byte(8'hA4, ack); acks += int'(ack);
        send_byte(8'hD2, ack); acks += int'(ack);
        for (int i = 0; i < 5; i++) begin send_byte(8'h00, ack); acks += int'(ack); end
        bus_stop();
        check(acks == 0, "R2 ignore until start", 32'(acks), 32'h0);
        check_outputs("R2 no change");

        // R12: extra bytes acknowledged and discarded
        bus_start();
        acks = 0;
        send_byte(8'hD2, ack); acks += int'(ack);
        send_byte(8'h11, ack); acks += int'(ack);
        send_byte(8'h22, ack); acks += int'(ack);
        send_byte(8'h05, ack); acks += int'(ack);
        send_byte(8'h50, ack); acks += int'(ack);
        send_byte(8'h40, ack); acks += int'(ack);
        send_byte(8'hFF, ack); acks += int'(ack);
        send_byte(8'hFF, ack); acks += int'(ack);
        bus_stop();
        model_write(0, 8'h05); model_write(1, 8'h50); model_write(2, 8'h40);
        check(acks == 8, "R12 extra acks", 32'(acks), 32'd8);
        check_outputs("R12 extra discarded");

        // R12: repeated START after data byte 0, then STOP mid data byte 0
        bus_start();
        send_byte(8'hD2, ack); send_byte(8'h00, ack); send_byte(8'h00, ack);
        send_byte(8'h0F, ack);
        model_write(0, 8'h0F);
        bus_start();
        send_byte(8'hD2, ack); send_byte(8'h00, ack); send_byte(8'h00, ack);
        send_bits(8'h00, 4);
        bus_stop();
        check_outputs("R12 abort keeps byte0, drops partial");

        // random frames
        for (int k = 0; k < 18; k++) begin
            a  = ($urandom % 5 == 0) ? 8'($urandom) : 8'hD2;
            c  = 8'($urandom); n  = 8'($urandom);
            d0 = 8'($urandom); d1 = 8'($urandom); d2 = 8'($urandom);
            frame(a, c, n, d0, d1, d2, "R9 random");
        end

        // R10: reset mid-run restores all enables
        frame(8'hD2, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, "R9 all off");
        rst_n = 1'b0; repeat (3) @(negedge clk); rst_n = 1'b1; @(negedge clk);
        exp_en = 10'h3FF;
        check_outputs("R10 re-reset");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule